// File: doc/BRIEF.md
# Dual-Precision Significand Rounder

This combinational stage finishes a floating-point operation. A producer hands it a significand that is already normalized, held in a wide accumulator. From the most significant bit down, the accumulator holds a carry position, the leading unit bit, a 52-bit fraction, and then guard, round and sticky bits. With it come a sign, a 13-bit biased exponent, a precision select and a rounding-mode code. The stage decides whether to add one unit in the last place and clears every fraction bit below the rounding point. If the increment ripples out of the top, it shifts the significand right by one and bumps the exponent. It reports whether the result is inexact and whether the rounded exponent is too large for the chosen format.

Both formats share the same accumulator. In single precision, the rounding point moves up into the fraction. The guard, round and sticky decisions are then taken from fixed positions inside it. Everything below the single-precision guard, including the double-level guard, round and sticky bits, folds into the sticky term. The exponent carries two bits beyond the double exponent field, so a value that has gone out of range is still seen as a signed number rather than wrapping.

Top module: `fp_sig_rounder`

## Requirements
- R1: With mode code 00 (nearest), the significand is incremented when the guard bit is 1 and either the round or sticky bit is 1, and is left truncated when the guard bit is 0.
- R2: With mode code 00 on an exact halfway case (guard 1, round 0, sticky 0), the result is incremented only when the least significant kept bit is 1, so the result always ends in a 0 bit.
- R3: With mode code 01 (toward zero), the significand is always truncated.
- R4: With mode code 10 (toward +infinity), an inexact positive value (sign 0) is incremented and a negative value is truncated.
- R5: With mode code 11 (toward -infinity), an inexact negative value (sign 1) is incremented and a positive value is truncated.
- R6: inexact_o is the OR of guard, round and sticky at the selected precision. When it is 0, the significand and exponent pass through unchanged.
- R7: acc_i bit 56 is the carry position (must be 0 on input), bits 55:3 are the unit bit plus fraction, and bits 2:0 are guard, round and sticky. With prec_dbl_i = 0, the last kept bit is fraction bit 23 (counting the unit bit as bit 0). Guard is bit 24, round is bit 25, and sticky is the OR of bits 26..52 with acc_i[2:0]. Output bits for fraction positions 24..52 are zero.
- R8: When the increment carries out of the unit bit, sig_o is the unit bit alone (1.000...0) and exp_o is exp_i + 1. Otherwise, exp_o equals exp_i.
- R9: ovf_o is 1 exactly when exp_o, read as a signed 13-bit value, exceeds 2046 in double precision or 254 in single precision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value being rounded (1 = negative) |
| exp_i | input | 13 | Biased exponent with two guard bits of headroom |
| prec_dbl_i | input | 1 | 1 = round to double, 0 = round to single |
| rmode_i | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| acc_i | input | 57 | Accumulator: carry, unit bit, 52 fraction bits, guard, round, sticky |
| sig_o | output | 53 | Rounded significand: unit bit and 52 fraction bits |
| exp_o | output | 13 | Exponent after carry-out adjustment |
| inexact_o | output | 1 | Some discarded bit was nonzero |
| ovf_o | output | 1 | Rounded exponent exceeds the format maximum |

## Verification
Each rounding mode is driven with the same significand under both signs. This separates the sign-directed modes from truncation and from the nearest mode. For the nearest mode, the tests cover halfway cases with an odd and with an even last bit. They also cover just-above-half and below-half patterns, which tell a correct tie-to-even apart from plain round-half-up. In single precision, the tests set bits only in the fraction region below bit 23, or only in the double-level sticky position. This shows that those bits feed the sticky term, and that they are cleared rather than kept. All-ones significands check the carry-out path at the exponent boundaries of both formats, where overflow must be raised or must stay quiet.

// File: rtl/fpr_pkg.sv
// Shared definitions for the significand rounder.
// Assumes: mode codes are fixed by the issuing unit and never change meaning.
package fpr_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_POS  = 2'b10,
        RM_NEG  = 2'b11
    } rmode_e;

endpackage

// File: rtl/fpr_grs_select.sv
// Picks the last-kept bit, guard, round and sticky for the chosen precision,
// and produces the keep mask and the unit-in-last-place increment value.
// Assumes: sig_i holds the unit bit at its MSB, followed by the fraction.
module fpr_grs_select #(
    parameter int FRAC_W     = 52,
    parameter int SGL_FRAC_W = 23
) (
    input  logic [FRAC_W:0] sig_i,
    input  logic            g_i,
    input  logic            r_i,
    input  logic            x_i,
    input  logic            dbl_i,
    output logic            lsb_o,
    output logic            guard_o,
    output logic            round_o,
    output logic            sticky_o,
    output logic [FRAC_W:0] keep_mask_o,
    output logic [FRAC_W:0] ulp_o
);
    localparam int SIG_W   = FRAC_W + 1;
    localparam int SGL_CUT = FRAC_W - SGL_FRAC_W;   // index of single-precision last bit

    logic sgl_lsb, sgl_guard, sgl_round, sgl_sticky;

    generate
        if (SGL_CUT >= 3) begin : g_sgl_taps
            // Taps for the single-precision rounding point inside the fraction.
            always_comb begin
                sgl_lsb    = sig_i[SGL_CUT];
                sgl_guard  = sig_i[SGL_CUT-1];
                sgl_round  = sig_i[SGL_CUT-2];
                sgl_sticky = (|sig_i[SGL_CUT-3:0]) | g_i | r_i | x_i;
            end
        end else begin : g_sgl_narrow
            // Degenerate layout: no room below the single point; fall back to double taps.
            always_comb begin
                sgl_lsb    = sig_i[0];
                sgl_guard  = g_i;
                sgl_round  = r_i;
                sgl_sticky = x_i;
            end
        end
    endgenerate

    // Select the taps and masks that match the requested precision.
    always_comb begin
        if (dbl_i) begin
            lsb_o       = sig_i[0];
            guard_o     = g_i;
            round_o     = r_i;
            sticky_o    = x_i;
            keep_mask_o = {SIG_W{1'b1}};
            ulp_o       = {{(SIG_W-1){1'b0}}, 1'b1};
        end else begin
            lsb_o       = sgl_lsb;
            guard_o     = sgl_guard;
            round_o     = sgl_round;
            sticky_o    = sgl_sticky;
            keep_mask_o = {SIG_W{1'b1}} << SGL_CUT;
            ulp_o       = {{(SIG_W-1){1'b0}}, 1'b1} << SGL_CUT;
        end
    end

    // Guard the mask shape: the increment lands on the lowest kept bit (R7).
    always_comb begin
        p_ulp_in_mask_r7: assert ((ulp_o & keep_mask_o) == ulp_o &&
                                  ((ulp_o - 1'b1) & keep_mask_o) == '0)
            else $error("ulp not at lowest kept bit");
    end

endmodule

// File: rtl/fpr_round_decide.sv
// Decides whether to add one unit in the last place for the given mode and sign.
// Assumes: taps are already chosen for the active precision.
module fpr_round_decide
    import fpr_pkg::*;
(
    input  logic [1:0] rmode_i,
    input  logic       sign_i,
    input  logic       lsb_i,
    input  logic       guard_i,
    input  logic       round_i,
    input  logic       sticky_i,
    output logic       inc_o,
    output logic       inexact_o
);
    rmode_e mode;
    logic   lost;

    // Mode-dependent increment decision.
    always_comb begin
        mode = rmode_e'(rmode_i);
        lost = guard_i | round_i | sticky_i;
        unique case (mode)
            RM_NEAR: inc_o = guard_i & (round_i | sticky_i | lsb_i);
            RM_ZERO: inc_o = 1'b0;
            RM_POS:  inc_o = lost & ~sign_i;
            RM_NEG:  inc_o = lost & sign_i;
            default: inc_o = 1'b0;
        endcase
        inexact_o = lost;
    end

    // Mode-level sanity checks kept next to the decision.
    always_comb begin
        p_inc_needs_loss_r1: assert (!inc_o || inexact_o)
            else $error("increment without discarded bits");
        p_tie_even_r2: assert (!(rmode_i == 2'b00 && guard_i && !round_i && !sticky_i) || (inc_o == lsb_i))
            else $error("tie not rounded to even");
        p_zero_no_inc_r3: assert (!(rmode_i == 2'b01) || !inc_o)
            else $error("toward-zero incremented");
        p_pos_neg_sign_r4: assert (!(rmode_i == 2'b10 && sign_i) || !inc_o)
            else $error("+inf mode incremented a negative value");
        p_neg_pos_sign_r5: assert (!(rmode_i == 2'b11 && !sign_i) || !inc_o)
            else $error("-inf mode incremented a positive value");
    end

endmodule

// File: rtl/fpr_sig_adjust.sv
// Clears discarded bits, applies the increment, renormalizes on carry-out,
// adjusts the exponent and flags overflow against the format maximum.
// Assumes: the incoming unit bit is set for normal values and the carry slot is empty.
module fpr_sig_adjust #(
    parameter int FRAC_W       = 52,
    parameter int EXP_W        = 13,
    parameter int DBL_EXP_BITS = 11,
    parameter int SGL_EXP_BITS = 8
) (
    input  logic [FRAC_W:0]  sig_i,
    input  logic [FRAC_W:0]  keep_mask_i,
    input  logic [FRAC_W:0]  ulp_i,
    input  logic             inc_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic             dbl_i,
    output logic [FRAC_W:0]  sig_o,
    output logic [EXP_W-1:0] exp_o,
    output logic             ovf_o
);
    localparam int SIG_W = FRAC_W + 1;
    localparam logic [EXP_W-1:0] DBL_MAX = EXP_W'((1 << DBL_EXP_BITS) - 2);
    localparam logic [EXP_W-1:0] SGL_MAX = EXP_W'((1 << SGL_EXP_BITS) - 2);

    logic [SIG_W:0] sum;
    logic           carry;

    // Truncate, add the increment, then shift right on carry-out.
    always_comb begin
        sum   = {1'b0, sig_i & keep_mask_i} + (inc_i ? {1'b0, ulp_i} : '0);
        carry = sum[SIG_W];
        sig_o = carry ? sum[SIG_W:1] : sum[SIG_W-1:0];
        exp_o = exp_i + {{(EXP_W-1){1'b0}}, carry};
    end

    // Signed compare against the largest finite exponent of the format.
    always_comb begin
        ovf_o = $signed(exp_o) > $signed(dbl_i ? DBL_MAX : SGL_MAX);
    end

    // Structural checks on the adjusted result.
    always_comb begin
        p_low_bits_clear_r7: assert ((sig_o & ~keep_mask_i) == '0)
            else $error("discarded bits not cleared");
        p_carry_renorm_r8: assert (!carry || sig_o == {1'b1, {(SIG_W-1){1'b0}}})
            else $error("carry-out not renormalized");
        p_exp_step_r8: assert (exp_o == exp_i || exp_o == exp_i + 1'b1)
            else $error("exponent moved by more than one");
    end

endmodule

// File: rtl/fp_sig_rounder.sv
// Top of the dual-precision significand rounder. Splits the accumulator,
// selects rounding taps, decides the increment and adjusts the result.
// Assumes: the accumulator arrives normalized with its carry slot at zero.
module fp_sig_rounder #(
    parameter int FRAC_W       = 52,
    parameter int SGL_FRAC_W   = 23,
    parameter int EXP_W        = 13,
    parameter int DBL_EXP_BITS = 11,
    parameter int SGL_EXP_BITS = 8
) (
    input  logic                sign_i,
    input  logic [EXP_W-1:0]    exp_i,
    input  logic                prec_dbl_i,
    input  logic [1:0]          rmode_i,
    input  logic [FRAC_W+4:0]   acc_i,
    output logic [FRAC_W:0]     sig_o,
    output logic [EXP_W-1:0]    exp_o,
    output logic                inexact_o,
    output logic                ovf_o
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int ACC_W = SIG_W + 4;

    logic             acc_carry;
    logic [SIG_W-1:0] sig_in;
    logic             g_bit, r_bit, x_bit;
    logic             lsb, guard, round_b, sticky, inc;
    logic [SIG_W-1:0] keep_mask, ulp;

    // Split the accumulator into its fields.
    always_comb begin
        acc_carry = acc_i[ACC_W-1];
        sig_in    = acc_i[ACC_W-2:3];
        g_bit     = acc_i[2];
        r_bit     = acc_i[1];
        x_bit     = acc_i[0];
    end

    fpr_grs_select #(.FRAC_W(FRAC_W), .SGL_FRAC_W(SGL_FRAC_W)) u_taps (
        .sig_i       (sig_in),
        .g_i         (g_bit),
        .r_i         (r_bit),
        .x_i         (x_bit),
        .dbl_i       (prec_dbl_i),
        .lsb_o       (lsb),
        .guard_o     (guard),
        .round_o     (round_b),
        .sticky_o    (sticky),
        .keep_mask_o (keep_mask),
        .ulp_o       (ulp)
    );

    fpr_round_decide u_decide (
        .rmode_i   (rmode_i),
        .sign_i    (sign_i),
        .lsb_i     (lsb),
        .guard_i   (guard),
        .round_i   (round_b),
        .sticky_i  (sticky),
        .inc_o     (inc),
        .inexact_o (inexact_o)
    );

    fpr_sig_adjust #(
        .FRAC_W       (FRAC_W),
        .EXP_W        (EXP_W),
        .DBL_EXP_BITS (DBL_EXP_BITS),
        .SGL_EXP_BITS (SGL_EXP_BITS)
    ) u_adjust (
        .sig_i       (sig_in),
        .keep_mask_i (keep_mask),
        .ulp_i       (ulp),
        .inc_i       (inc),
        .exp_i       (exp_i),
        .dbl_i       (prec_dbl_i),
        .sig_o       (sig_o),
        .exp_o       (exp_o),
        .ovf_o       (ovf_o)
    );

    // End-to-end checks across the three stages.
    always_comb begin
        p_carry_slot_empty_r7: assert (!acc_carry)
            else $error("accumulator carry slot set on input");
        p_exact_passthru_r6: assert (inexact_o || (sig_o == sig_in && exp_o == exp_i))
            else $error("exact value altered");
        p_no_overflow_r9: assert (!ovf_o || $signed(exp_o) > $signed(EXP_W'((1 << SGL_EXP_BITS) - 2)))
            else $error("overflow flagged below single maximum");
    end

endmodule

// File: tb/fp_sig_rounder_tb_top.sv
module fp_sig_rounder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sign_i = 1'b0;
    logic [12:0] exp_i = '0;
    logic        prec_dbl_i = 1'b0;
    logic [1:0]  rmode_i = 2'b00;
    logic [56:0] acc_i = '0;
    logic [52:0] sig_o;
    logic [12:0] exp_o;
    logic        inexact_o, ovf_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    localparam logic [52:0] ONE  = 53'h10000000000000;
    localparam logic [52:0] ALL1 = 53'h1FFFFFFFFFFFFF;
    localparam logic [52:0] B28  = 53'h00000010000000;
    localparam logic [52:0] B29  = 53'h00000020000000;
    localparam logic [52:0] B30  = 53'h00000040000000;

    fp_sig_rounder dut_i (
        .sign_i(sign_i), .exp_i(exp_i), .prec_dbl_i(prec_dbl_i), .rmode_i(rmode_i),
        .acc_i(acc_i), .sig_o(sig_o), .exp_o(exp_o), .inexact_o(inexact_o), .ovf_o(ovf_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic drive(input logic s, input logic [12:0] e, input logic dbl, input logic [1:0] m,
                         input logic [52:0] sig, input logic g, input logic r, input logic x);
        @(negedge clk);
        sign_i = s; exp_i = e; prec_dbl_i = dbl; rmode_i = m;
        acc_i = {1'b0, sig, g, r, x};
        #2;
    endtask

    task automatic t_idle;
        drive(0, 13'd0, 1, 2'b00, '0, 0, 0, 0);
        chk("R6 idle sig", 64'(sig_o), 64'd0);
        chk("R6 idle inexact", 64'(inexact_o), 64'd0);
        chk("R9 idle ovf", 64'(ovf_o), 64'd0);
    endtask

    task automatic t_nearest;
        drive(0, 13'd1023, 1, 2'b00, ONE, 1, 1, 0);
        chk("R1 near up", 64'(sig_o), 64'(ONE + 1));
        chk("R1 near up inexact", 64'(inexact_o), 64'd1);
        chk("R8 near up exp", 64'(exp_o), 64'd1023);
        drive(0, 13'd1023, 1, 2'b00, ONE | 53'd1, 0, 1, 1);
        chk("R1 near down", 64'(sig_o), 64'(ONE | 53'd1));
    endtask

    task automatic t_tie;
        drive(0, 13'd10, 1, 2'b00, ONE, 1, 0, 0);
        chk("R2 tie even stays", 64'(sig_o), 64'(ONE));
        drive(1, 13'd10, 1, 2'b00, ONE | 53'd1, 1, 0, 0);
        chk("R2 tie odd rounds up", 64'(sig_o), 64'(ONE | 53'd2));
    endtask

    task automatic t_zero;
        drive(0, 13'd5, 1, 2'b01, ONE | 53'd1, 1, 1, 1);
        chk("R3 toward zero", 64'(sig_o), 64'(ONE | 53'd1));
        chk("R3 inexact", 64'(inexact_o), 64'd1);
    endtask

    task automatic t_directed;
        drive(0, 13'd5, 1, 2'b10, ONE, 0, 0, 1);
        chk("R4 +inf positive", 64'(sig_o), 64'(ONE + 1));
        drive(1, 13'd5, 1, 2'b10, ONE, 0, 0, 1);
        chk("R4 +inf negative", 64'(sig_o), 64'(ONE));
        drive(1, 13'd5, 1, 2'b11, ONE, 0, 0, 1);
        chk("R5 -inf negative", 64'(sig_o), 64'(ONE + 1));
        drive(0, 13'd5, 1, 2'b11, ONE, 0, 0, 1);
        chk("R5 -inf positive", 64'(sig_o), 64'(ONE));
    endtask

    task automatic t_exact;
        drive(0, 13'd77, 1, 2'b10, ONE | 53'd5, 0, 0, 0);
        chk("R6 exact sig", 64'(sig_o), 64'(ONE | 53'd5));
        chk("R6 exact flag", 64'(inexact_o), 64'd0);
        chk("R6 exact exp", 64'(exp_o), 64'd77);
    endtask

    task automatic t_single;
        drive(0, 13'd127, 0, 2'b00, ONE | B29 | B28 | 53'd1, 0, 0, 0);
        chk("R7 single near up", 64'(sig_o), 64'(ONE | B30));
        chk("R7 single inexact", 64'(inexact_o), 64'd1);
        drive(0, 13'd127, 0, 2'b00, ONE | B28, 0, 0, 0);
        chk("R7 single tie even", 64'(sig_o), 64'(ONE));
        drive(0, 13'd127, 0, 2'b10, ONE, 0, 0, 1);
        chk("R7 single sticky from low x", 64'(sig_o), 64'(ONE | B29));
        drive(0, 13'd127, 0, 2'b01, ONE | B29 | 53'h3FF, 0, 0, 0);
        chk("R7 single low bits cleared", 64'(sig_o), 64'(ONE | B29));
        drive(0, 13'd127, 0, 2'b00, ONE | B29, 0, 0, 0);
        chk("R7 single exact", 64'(inexact_o), 64'd0);
    endtask

    task automatic t_carry;
        drive(0, 13'd100, 1, 2'b00, ALL1, 1, 0, 0);
        chk("R8 double carry sig", 64'(sig_o), 64'(ONE));
        chk("R8 double carry exp", 64'(exp_o), 64'd101);
        drive(0, 13'd100, 0, 2'b10, ALL1, 0, 0, 0);
        chk("R8 single carry sig", 64'(sig_o), 64'(ONE));
        chk("R8 single carry exp", 64'(exp_o), 64'd101);
    endtask

    task automatic t_ovf;
        drive(0, 13'd2046, 1, 2'b00, ALL1, 1, 1, 0);
        chk("R9 double carry ovf", 64'(ovf_o), 64'd1);
        drive(0, 13'd2046, 1, 2'b00, ONE, 0, 0, 0);
        chk("R9 double max no ovf", 64'(ovf_o), 64'd0);
        drive(0, 13'd254, 0, 2'b00, ALL1, 0, 0, 0);
        chk("R9 single carry ovf", 64'(ovf_o), 64'd1);
        drive(0, 13'd254, 0, 2'b00, ONE, 0, 0, 0);
        chk("R9 single max no ovf", 64'(ovf_o), 64'd0);
        drive(0, 13'd255, 0, 2'b01, ONE, 0, 0, 0);
        chk("R9 single above max", 64'(ovf_o), 64'd1);
        drive(0, 13'h1FF0, 1, 2'b00, ONE, 0, 0, 0);
        chk("R9 negative exp no ovf", 64'(ovf_o), 64'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_nearest();
        t_tie();
        t_zero();
        t_directed();
        t_exact();
        t_single();
        t_carry();
        t_ovf();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule